// File: doc/BRIEF.md
# Segmented Current-Steering DAC Decoder

This block turns one parallel DAC input word into the switch controls of a segmented current-steering cell array. The word is split into two fields. The upper field is expanded into a thermometer code. Each thermometer line drives one cell of equal weight. The lower field goes straight to a row of binary-weighted cells.

Every control line leaves the block from a single output register. That register is loaded on one clock edge, so the coarse and fine cells always switch together. Both field widths are parameters. The default is a 16-bit word with 6 upper bits and 10 lower bits, which gives 63 + 10 = 73 switch controls. A small 3 + 3 build gives 7 thermometer lines and 3 binary lines.

Top module: `seg_dac_decoder`

## Requirements
- R1: While the active-low reset is asserted, every thermometer and binary output is 0.
- R2: The thermometer bus is 2^MSB_BITS-1 lines wide. When the upper input field holds the value k, exactly the lowest k lines (bits k-1 down to 0) are 1 and all the others are 0.
- R3: Each bit i of the lower input field appears unchanged on binary output bit i.
- R4: All outputs show the word sampled at the previous rising clock edge, giving one cycle of latency. Between edges they keep their old value, and both segments update on the same edge.
- R5: An all-zero input word drives every output low. An all-ones input word drives every output high.
- R6: Each thermometer line carries a weight of 2^LSB_BITS, which is twice the weight of the largest binary line. So (number of thermometer lines that are 1) × 2^LSB_BITS + binary value equals the registered input word.
- R7: In the 3 + 3 build, upper value 3 gives thermometer output 0000111, and the 3 lower bits stay binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the outputs register on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | MSB_BITS+LSB_BITS | DAC input word |
| therm_out | output | 2^MSB_BITS-1 | Controls for the equal-weight cells; bit 0 switches first |
| bin_out | output | LSB_BITS | Controls for the binary-weighted cells; bit i has weight 2^i |

## Verification
The bench builds two copies of the block side by side. One uses the default 6 + 10 split. The other uses the 3 + 3 split. In the small build, all eight thermometer levels fit in a short literal table of exact expected bit patterns. The wide build reaches the 63-line boundary cases: empty, one line, half, one short of full, and full. It also exercises the 10-bit binary field with full, empty and alternating patterns.

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int MSB_BITS = 6,
  parameter int LSB_BITS = 10,
  localparam int WORD_W  = MSB_BITS + LSB_BITS,
  localparam int THERM_W = (1 << MSB_BITS) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  code_in,
  output logic [THERM_W-1:0] therm_out,
  output logic [LSB_BITS-1:0] bin_out
);

  logic [MSB_BITS-1:0] seg_hi;
  logic [THERM_W-1:0]  therm_next;

  assign seg_hi = code_in[WORD_W-1:LSB_BITS];

  for (genvar i = 0; i < THERM_W; i++) begin : g_therm
    assign therm_next[i] = (seg_hi > MSB_BITS'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_out <= '0;
      bin_out   <= '0;
    end else begin
      therm_out <= therm_next;
      bin_out   <= code_in[LSB_BITS-1:0];
    end
  end

endmodule

module seg_dac_decoder_chk #(
  parameter int MSB_BITS = 6,
  parameter int LSB_BITS = 10,
  localparam int WORD_W  = MSB_BITS + LSB_BITS,
  localparam int THERM_W = (1 << MSB_BITS) - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  code_in,
  input logic [THERM_W-1:0] therm_out,
  input logic [LSB_BITS-1:0] bin_out
);

  logic [THERM_W:0] therm_plus;
  assign therm_plus = {1'b0, therm_out} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (therm_out == '0 && bin_out == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  assert_therm_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(therm_plus));

  assert_therm_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $countones(therm_out) == int'($past(code_in[WORD_W-1:LSB_BITS])));

  assert_bin_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> bin_out == $past(code_in[LSB_BITS-1:0]));

  assert_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_in == '1) |=> (therm_out == '1 && bin_out == '1));

  assert_all_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_in == '0) |=> (therm_out == '0 && bin_out == '0));

endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(.MSB_BITS(MSB_BITS), .LSB_BITS(LSB_BITS)) chk (
  .clk(clk), .rst_n(rst_n), .code_in(code_in), .therm_out(therm_out), .bin_out(bin_out)
);

// File: tb/seg_dac_decoder_test.sv
module seg_dac_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] code_big = '0;
  logic [5:0]  code_small = '0;
  logic [62:0] therm_big;
  logic [9:0]  bin_big;
  logic [6:0]  therm_small;
  logic [2:0]  bin_small;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_dac_decoder uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_big), .therm_out(therm_big), .bin_out(bin_big)
  );

  seg_dac_decoder #(.MSB_BITS(3), .LSB_BITS(3)) uut_small (
    .clk(clk), .rst_n(rst_n), .code_in(code_small), .therm_out(therm_small), .bin_out(bin_small)
  );

  // {code[5:0], therm[6:0], bin[2:0]}
  localparam logic [15:0] SMALL_VEC [8] = '{
    {6'b000000, 7'b0000000, 3'b000},
    {6'b000111, 7'b0000000, 3'b111},
    {6'b001000, 7'b0000001, 3'b000},
    {6'b011101, 7'b0000111, 3'b101},
    {6'b100010, 7'b0001111, 3'b010},
    {6'b101110, 7'b0011111, 3'b110},
    {6'b110001, 7'b0111111, 3'b001},
    {6'b111111, 7'b1111111, 3'b111}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [62:0] therm_of(input int k);
    logic [62:0] t = '0;
    for (int i = 0; i < k; i++) t[i] = 1'b1;
    return t;
  endfunction

  task automatic apply_big(input logic [15:0] w, input string req);
    logic [62:0] old_t;
    @(negedge clk);
    old_t = therm_big;
    code_big = w;
    #1;
    check("R4 hold before edge", {1'b0, therm_big}, {1'b0, old_t});
    @(negedge clk);
    check(req, {1'b0, therm_big}, {1'b0, therm_of(int'(w[15:10]))});
    check("R3 binary field", 64'(bin_big), 64'(w[9:0]));
    check("R6 weight sum", 64'($countones(therm_big)) * 64'd1024 + 64'(bin_big), 64'(w));
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset therm", {1'b0, therm_big}, 64'd0);
    check("R1 reset bin", 64'(bin_big), 64'd0);
    check("R1 reset small", 64'({therm_small, bin_small}), 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      code_small = SMALL_VEC[v][15:10];
      @(negedge clk);
      check("R2 R7 small therm", 64'(therm_small), 64'(SMALL_VEC[v][9:3]));
      check("R3 small bin", 64'(bin_small), 64'(SMALL_VEC[v][2:0]));
    end

    apply_big(16'h0000, "R5 all zero");
    check("R5 zero bin", 64'(bin_big), 64'd0);
    apply_big(16'hFFFF, "R5 all ones");
    check("R5 ones bin", 64'(bin_big), 64'h3FF);
    apply_big(16'h0400, "R2 one line");
    apply_big(16'h83FF, "R2 half");
    apply_big(16'hFBFF, "R2 one short of full");
    apply_big(16'h7C00, "R2 31 lines");
    apply_big(16'h0155, "R3 alternating");
    apply_big(16'h02AA, "R3 alternating inverse");

    // R4: both segments move on the same edge
    @(negedge clk);
    code_big = 16'h0000;
    @(negedge clk);
    code_big = 16'hFFFF;
    @(posedge clk);
    #0.5;
    check("R4 same edge therm", {1'b0, therm_big}, {1'b0, therm_of(63)});
    check("R4 same edge bin", 64'(bin_big), 64'h3FF);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run therm", {1'b0, therm_big}, 64'd0);
    check("R1 mid-run bin", 64'(bin_big), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule